// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block finds the vertical sync interval in a sliced, active-low composite sync stream. It is clocked at a fixed sample rate, and it is given a one-cycle line-start strobe from an existing horizontal timing path. It measures how long each sync pulse stays low. A pulse much wider than a normal horizontal sync is taken as a broad (vertical) pulse, and a run of three such pulses marks the start of a new field or frame.

When the run is confirmed, the block drives an active-low vertical pulse of fixed length. On the same clock edge it starts an active-low coast window, which lets a downstream line-locked oscillator free-run through vertical blanking, and it updates an odd/even field flag. For interlaced inputs the field flag is taken from the line phase at which the first broad pulse began. A separate watchdog raises a sync-lost flag when the sync input stops toggling, and clears the flag once sync has been steady again for some time. The video standard is supplied as a two-bit code by an external classifier.

Top module: `vsd_vertical_detector`

## Requirements
- R1: While `rst_n` is sampled low, the block resets. Afterwards `vsync_n`=1, `coast_n`=1, `field_even`=0 and `sync_lost`=1.
- R2: A sync pulse is broad when `csync_n` is sampled low on more than 2*HSYNC_CLKS consecutive clocks. A pulse of exactly 2*HSYNC_CLKS clocks is not broad.
- R3: The vertical event is the clock where `csync_n` is first sampled high after the third broad pulse in a row. `vsync_n` goes low on the next clock and stays low for VPULSE_CLKS clocks. A run of more than three broad pulses produces only one event.
- R4: At a vertical event with `std_mode[0]`=1 (interlaced), `field_even` becomes 1 if the first broad pulse of the run started when the line phase was between LINE_CLKS/4 and 3*LINE_CLKS/4 (lower bound included, upper bound excluded). The line phase is the number of clocks since the last `line_strobe`. Otherwise `field_even` becomes 0. The flag changes on the same clock as the fall of `vsync_n` and holds its value between events.
- R5: At a vertical event with `std_mode[0]`=0 (progressive), `field_even` becomes 0 whatever the pulse phase.
- R6: `coast_n` goes low together with `vsync_n`. It returns high at the Nth `line_strobe` after the event. N is COAST_HD_LINES when `std_mode[1]`=1 and COAST_SD_LINES when `std_mode[1]`=0.
- R7: `sync_lost` is set after LOSS_LINES*LINE_CLKS consecutive clocks with no change of `csync_n`.
- R8: While lost, each falling edge of `csync_n` counts one valid line. On the RECOVER_LINES-th count `sync_lost` clears. A timeout restarts the count.
- R9: A pulse that is not broad, arriving in a run, resets the run count. Two broad pulses, then a normal pulse, then one broad pulse produce no vertical event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csync_n | input | 1 | Sliced composite sync, low during sync |
| line_strobe | input | 1 | One-cycle pulse at each nominal line start |
| std_mode | input | 2 | Bit 0 interlaced, bit 1 high definition |
| vsync_n | output | 1 | Vertical pulse, active low |
| field_even | output | 1 | 1 for an even field, 0 for odd or progressive |
| coast_n | output | 1 | Vertical blanking coast window, active low |
| sync_lost | output | 1 | High while no sync is present |

## Verification
The bench builds the block with a 40-clock line, a 4-clock horizontal sync and a 6-clock vertical pulse. These settings put the broad-pulse threshold at 8 and 9 low clocks, so both sides of it can be driven with short lines. They also keep the half-line phase window, the 160-clock sync-loss timeout and the 20- and 25-line coast windows within a few thousand cycles. The coast line counts and the loss and recovery counts keep their default values, so the exact line on which each window ends is checked as specified.

// File: rtl/vsd_pkg.sv
// Shared types for the vertical sync and field detector.
// Assumes the standard code arrives as two independent flag bits.
package vsd_pkg;

    // Standard code: bit 1 high definition, bit 0 interlaced.
    typedef struct packed {
        logic hd;
        logic interlaced;
    } vsd_std_t;

    // Larger of two line counts, for sizing a shared counter.
    function automatic int vsd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vsd_line_phase.sv
// Counts clocks since the last line-start strobe and flags the mid-line window.
// Assumes the strobe is one clock wide; the count saturates if strobes stop.
module vsd_line_phase #(
    parameter int LINE_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_strobe,
    output logic mid_line
);
    localparam int PW = $clog2(LINE_CLKS) + 1;
    localparam logic [PW-1:0] MID_LO = PW'(LINE_CLKS / 4);
    localparam logic [PW-1:0] MID_HI = PW'((3 * LINE_CLKS) / 4);

    logic [PW-1:0] phase;

    // Phase counter: restart on strobe, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (line_strobe)
            phase <= '0;
        else if (phase != '1)
            phase <= phase + 1'b1;
    end

    assign mid_line = (phase >= MID_LO) && (phase < MID_HI);
endmodule

// File: rtl/vsd_broad_det.sv
// Measures each sync low time, counts consecutive broad pulses and raises a
// one-cycle vertical event on the rising edge that ends the third of them.
// Also records whether the first broad pulse of a run began mid-line.
// Assumes csync_n is already synchronous to clk.
module vsd_broad_det #(
    parameter int HSYNC_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    input  logic mid_line,
    output logic sync_fall,
    output logic sync_edge,
    output logic v_event,
    output logic first_mid
);
    localparam int TH_INT = 2 * HSYNC_CLKS + 1;
    localparam int LW = $clog2(TH_INT + 1);
    localparam logic [LW-1:0] BROAD_TH = LW'(TH_INT);

    logic          sync_q;
    logic [LW-1:0] low_cnt;
    logic [1:0]    run_cnt;
    logic          fall_mid;
    logic          sync_rise;
    logic          is_broad;

    assign sync_fall = sync_q & ~csync_n;
    assign sync_rise = ~sync_q & csync_n;
    assign sync_edge = sync_fall | sync_rise;
    assign is_broad  = (low_cnt == BROAD_TH);
    assign v_event   = sync_rise & is_broad & (run_cnt == 2'd2);

    // Previous sample of the sync input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b1;
        else        sync_q <= csync_n;
    end

    // Low-time counter, saturating at the broad threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (sync_fall)
            low_cnt <= LW'(1);
        else if (!csync_n && !is_broad)
            low_cnt <= low_cnt + 1'b1;
    end

    // Run length of consecutive broad pulses, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (sync_rise)
            run_cnt <= !is_broad ? 2'd0 : (run_cnt == 2'd3) ? 2'd3 : run_cnt + 2'd1;
    end

    // Line phase of each pulse start, and of the first broad pulse of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_mid  <= 1'b0;
            first_mid <= 1'b0;
        end else begin
            if (sync_fall)
                fall_mid <= mid_line;
            if (sync_rise && is_broad && run_cnt == 2'd0)
                first_mid <= fall_mid;
        end
    end
endmodule

// File: rtl/vsd_sync_loss.sv
// Sync-loss watchdog: declares loss after a quiet window with no sync edge and
// clears it after a number of sync falling edges without a further timeout.
// Assumes edge strobes come from the broad-pulse detector in the same cycle.
module vsd_sync_loss #(
    parameter int LOSS_CLKS     = 256,
    parameter int RECOVER_LINES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_edge,
    input  logic sync_fall,
    output logic sync_lost
);
    localparam int IW = $clog2(LOSS_CLKS + 1);
    localparam int RW = $clog2(RECOVER_LINES + 1);
    localparam logic [IW-1:0] LOSS_LIM = IW'(LOSS_CLKS);
    localparam logic [RW-1:0] REC_LAST = RW'(RECOVER_LINES - 1);

    logic [IW-1:0] idle_cnt;
    logic [IW-1:0] idle_nxt;
    logic [RW-1:0] good_cnt;

    // Next quiet count: cleared by any edge, saturating at the limit.
    always_comb begin
        if (sync_edge)
            idle_nxt = '0;
        else if (idle_cnt == LOSS_LIM)
            idle_nxt = idle_cnt;
        else
            idle_nxt = idle_cnt + 1'b1;
    end

    // Quiet counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_cnt <= '0;
        else        idle_cnt <= idle_nxt;
    end

    // Loss flag and recovery line counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_lost <= 1'b1;
            good_cnt  <= '0;
        end else if (!sync_edge && idle_nxt == LOSS_LIM) begin
            sync_lost <= 1'b1;
            good_cnt  <= '0;
        end else if (sync_fall && sync_lost) begin
            if (good_cnt == REC_LAST) begin
                sync_lost <= 1'b0;
                good_cnt  <= '0;
            end else begin
                good_cnt <= good_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vsd_vertical_detector.sv
// Top of the vertical sync and field detector. Generates the vertical pulse,
// the field flag and the coast window from the broad-pulse event, and hosts
// the sync-loss watchdog. Assumes std_mode is stable around vertical events.
module vsd_vertical_detector
    import vsd_pkg::*;
#(
    parameter int LINE_CLKS      = 64,
    parameter int HSYNC_CLKS     = 5,
    parameter int VPULSE_CLKS    = 10,
    parameter int COAST_SD_LINES = 20,
    parameter int COAST_HD_LINES = 25,
    parameter int LOSS_LINES     = 4,
    parameter int RECOVER_LINES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csync_n,
    input  logic       line_strobe,
    input  logic [1:0] std_mode,
    output logic       vsync_n,
    output logic       field_even,
    output logic       coast_n,
    output logic       sync_lost
);
    localparam int LOSS_CLKS = LOSS_LINES * LINE_CLKS;
    localparam int COAST_MAX = vsd_max(COAST_SD_LINES, COAST_HD_LINES);
    localparam int VW = $clog2(VPULSE_CLKS + 1);
    localparam int CW = $clog2(COAST_MAX + 1);

    vsd_std_t      std_s;
    logic          mid_line;
    logic          sync_fall;
    logic          sync_edge;
    logic          v_event;
    logic          first_mid;
    logic [VW-1:0] v_left;
    logic [CW-1:0] coast_left;

    assign std_s = vsd_std_t'(std_mode);

    vsd_line_phase #(.LINE_CLKS(LINE_CLKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .mid_line(mid_line)
    );

    vsd_broad_det #(.HSYNC_CLKS(HSYNC_CLKS)) u_broad (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .mid_line(mid_line),
        .sync_fall(sync_fall), .sync_edge(sync_edge),
        .v_event(v_event), .first_mid(first_mid)
    );

    vsd_sync_loss #(.LOSS_CLKS(LOSS_CLKS), .RECOVER_LINES(RECOVER_LINES)) u_loss (
        .clk(clk), .rst_n(rst_n), .sync_edge(sync_edge), .sync_fall(sync_fall),
        .sync_lost(sync_lost)
    );

    // Vertical pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            v_left <= '0;
        else if (v_event)
            v_left <= VW'(VPULSE_CLKS);
        else if (v_left != '0)
            v_left <= v_left - 1'b1;
    end

    // Field parity, updated only at a vertical event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_even <= 1'b0;
        else if (v_event)
            field_even <= std_s.interlaced & first_mid;
    end

    // Coast window in lines, loaded per standard and counted down on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            coast_left <= '0;
        else if (v_event)
            coast_left <= std_s.hd ? CW'(COAST_HD_LINES) : CW'(COAST_SD_LINES);
        else if (line_strobe && coast_left != '0)
            coast_left <= coast_left - 1'b1;
    end

    assign vsync_n = (v_left == '0);
    assign coast_n = (coast_left == '0);
endmodule

// File: rtl/vsd_checker.sv
// Assertion checker for the vertical sync and field detector, bound to the top.
// Observes ports only; keeps its own small counters for long windows.
module vsd_checker #(
    parameter int LINE_CLKS   = 64,
    parameter int VPULSE_CLKS = 10,
    parameter int LOSS_LINES  = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       csync_n,
    input logic [1:0] std_mode,
    input logic       vsync_n,
    input logic       field_even,
    input logic       coast_n,
    input logic       sync_lost
);
    localparam int LOSS_CLKS = LOSS_LINES * LINE_CLKS;

    logic cs_q;
    int   quiet;
    int   vlow;

    // Clocks since the last change of csync_n, and length of the current vsync_n low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            quiet <= 0;
            vlow  <= 0;
        end else begin
            cs_q  <= csync_n;
            quiet <= (cs_q != csync_n) ? 0 : ((quiet < LOSS_CLKS) ? quiet + 1 : quiet);
            vlow  <= vsync_n ? 0 : vlow + 1;
        end
    end

    p_vpulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> vlow < VPULSE_CLKS);

    p_vpulse_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(vsync_n) |-> $past(csync_n) && !$past(csync_n, 2));

    p_field_moves_with_vpulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(field_even) |-> $fell(vsync_n));

    p_progressive_field_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(vsync_n) && !$past(std_mode[0]) |-> !field_even);

    p_coast_covers_vpulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(vsync_n) |-> !coast_n);

    p_loss_after_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(sync_lost) |-> quiet >= LOSS_CLKS);

    p_loss_clear_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $fell(sync_lost) |-> !$past(csync_n) && $past(csync_n, 2));
endmodule

bind vsd_vertical_detector vsd_checker #(
    .LINE_CLKS(LINE_CLKS), .VPULSE_CLKS(VPULSE_CLKS), .LOSS_LINES(LOSS_LINES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .std_mode(std_mode),
    .vsync_n(vsync_n), .field_even(field_even), .coast_n(coast_n), .sync_lost(sync_lost)
);

// File: tb/tb_vsd_vertical_detector.sv
module tb_vsd_vertical_detector;
    localparam int L   = 40;
    localparam int H   = 4;
    localparam int V   = 6;
    localparam int CSD = 20;
    localparam int CHD = 25;
    localparam int LOSS = 4 * L;
    localparam int REC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic href = 1'b0;
    logic [1:0] std = 2'b00;
    logic vs_n, fe, co_n, lost;

    int vectors = 0;
    int fails = 0;
    int vfalls = 0;
    logic prev_vs = 1'b1;

    // Reference model state (behavioural).
    int m_prev = 1, m_low = 0, m_bcnt = 0, m_fm = 0, m_first = 0, m_phase = 0;
    int m_vleft = 0, m_fe = 0, m_cl = 0, m_idle = 0, m_lost = 1, m_good = 0;

    always #10 clk = ~clk;

    vsd_vertical_detector #(
        .LINE_CLKS(L), .HSYNC_CLKS(H), .VPULSE_CLKS(V),
        .COAST_SD_LINES(CSD), .COAST_HD_LINES(CHD), .LOSS_LINES(4), .RECOVER_LINES(REC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .csync_n(cs_n), .line_strobe(href), .std_mode(std),
        .vsync_n(vs_n), .field_even(fe), .coast_n(co_n), .sync_lost(lost)
    );

    // Reference model advanced on every rising edge.
    always @(posedge clk) begin : model
        int fall, rise, vf, cs, broad;
        cs = int'(cs_n);
        if (!rst_n) begin
            m_prev = 1; m_low = 0; m_bcnt = 0; m_fm = 0; m_first = 0; m_phase = 0;
            m_vleft = 0; m_fe = 0; m_cl = 0; m_idle = 0; m_lost = 1; m_good = 0;
        end else begin
            fall  = (m_prev == 1 && cs == 0) ? 1 : 0;
            rise  = (m_prev == 0 && cs == 1) ? 1 : 0;
            broad = (m_low > 2 * H) ? 1 : 0;
            vf    = (rise == 1 && broad == 1 && m_bcnt == 2) ? 1 : 0;
            if (vf == 1) begin
                m_vleft = V;
                m_fe = (std[0] == 1'b1) ? m_first : 0;
                m_cl = std[1] ? CHD : CSD;
            end else begin
                if (m_vleft > 0) m_vleft--;
                if (href && m_cl > 0) m_cl--;
            end
            if (rise == 1) begin
                if (broad == 1) begin
                    if (m_bcnt == 0) m_first = m_fm;
                    m_bcnt = (m_bcnt < 3) ? m_bcnt + 1 : 3;
                end else m_bcnt = 0;
            end
            if (fall == 1) begin
                m_fm = (m_phase >= L / 4 && m_phase < (3 * L) / 4) ? 1 : 0;
                m_low = 1;
            end else if (cs == 0 && m_low < 2 * H + 1) m_low++;
            if (fall == 1 || rise == 1) m_idle = 0;
            else if (m_idle < LOSS) m_idle++;
            if (fall == 0 && rise == 0 && m_idle >= LOSS) begin
                m_lost = 1; m_good = 0;
            end else if (fall == 1 && m_lost == 1) begin
                m_good++;
                if (m_good == REC) begin m_lost = 0; m_good = 0; end
            end
            m_phase = href ? 0 : ((m_phase < L) ? m_phase + 1 : L);
            m_prev = cs;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        vectors++;
        if (vs_n !== (m_vleft == 0)) begin
            fails++; $display("FAIL R3 vsync_n act=%b exp=%b t=%0t", vs_n, (m_vleft == 0), $time);
        end
        if (fe !== (m_fe != 0)) begin
            fails++; $display("FAIL R4 field_even act=%b exp=%b t=%0t", fe, (m_fe != 0), $time);
        end
        if (co_n !== (m_cl == 0)) begin
            fails++; $display("FAIL R6 coast_n act=%b exp=%b t=%0t", co_n, (m_cl == 0), $time);
        end
        if (lost !== (m_lost != 0)) begin
            fails++; $display("FAIL R7 sync_lost act=%b exp=%b t=%0t", lost, (m_lost != 0), $time);
        end
        if (prev_vs && !vs_n) vfalls++;
        prev_vs = vs_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // One line: strobe at clock 0, sync low in up to two windows.
    task automatic drive_line(input int a0, input int alen, input int b0, input int blen);
        for (int c = 0; c < L; c++) begin
            @(negedge clk);
            href = (c == 0);
            cs_n = !((c >= a0 && c < a0 + alen) || (c >= b0 && c < b0 + blen));
        end
    endtask

    task automatic normal_lines(input int n);
        for (int i = 0; i < n; i++) drive_line(0, H, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        int base;
        repeat (3) @(negedge clk);
        chk("R1 vsync_n", int'(vs_n), 1);
        chk("R1 coast_n", int'(co_n), 1);
        chk("R1 field_even", int'(fe), 0);
        chk("R1 sync_lost", int'(lost), 1);
        rst_n = 1'b1;
        normal_lines(15);
        chk("R8 still lost after 15 lines", int'(lost), 1);
        normal_lines(1);
        chk("R8 cleared after 16 lines", int'(lost), 0);

        // Progressive HD: three full-line broad pulses.
        std = 2'b10;
        normal_lines(2);
        base = vfalls;
        for (int i = 0; i < 3; i++) drive_line(0, L - H, 0, 0);
        chk("R3 one vertical pulse", vfalls - base, 1);
        chk("R5 progressive field low", int'(fe), 0);
        normal_lines(24);
        chk("R6 HD coast held after 24 strobes", int'(co_n), 0);
        normal_lines(1);
        chk("R6 HD coast released at 25th strobe", int'(co_n), 1);

        // Interlaced SD, odd field: broad pulses start at line start.
        std = 2'b01;
        normal_lines(2);
        base = vfalls;
        for (int i = 0; i < 3; i++) drive_line(0, L / 2 - H, L / 2, L / 2 - H);
        chk("R3 six broad pulses give one event", vfalls - base, 1);
        chk("R4 odd field", int'(fe), 0);
        normal_lines(18);
        chk("R6 SD coast held after 19 strobes", int'(co_n), 0);
        normal_lines(1);
        chk("R6 SD coast released at 20th strobe", int'(co_n), 1);

        // Interlaced SD, even field: first broad pulse at mid-line.
        base = vfalls;
        drive_line(0, H, L / 2, L / 2 - H);
        for (int i = 0; i < 2; i++) drive_line(0, L / 2 - H, L / 2, L / 2 - H);
        chk("R3 even field event", vfalls - base, 1);
        chk("R4 even field", int'(fe), 1);
        normal_lines(20);
        chk("R4 field holds between events", int'(fe), 1);

        // Progressive SD with mid-line start: field forced low.
        std = 2'b00;
        base = vfalls;
        drive_line(0, H, L / 2, L / 2 - H);
        for (int i = 0; i < 2; i++) drive_line(0, L / 2 - H, L / 2, L / 2 - H);
        chk("R5 event in progressive", vfalls - base, 1);
        chk("R5 progressive field low", int'(fe), 0);
        normal_lines(22);

        // Broad threshold boundary.
        base = vfalls;
        for (int i = 0; i < 3; i++) drive_line(0, 2 * H, 0, 0);
        normal_lines(1);
        chk("R2 width 2*H not broad", vfalls - base, 0);
        base = vfalls;
        for (int i = 0; i < 3; i++) drive_line(0, 2 * H + 1, 0, 0);
        normal_lines(1);
        chk("R2 width 2*H+1 broad", vfalls - base, 1);
        normal_lines(22);

        // Normal pulse breaks a broad run.
        base = vfalls;
        drive_line(0, L - H, 0, 0);
        drive_line(0, L - H, 0, 0);
        normal_lines(1);
        drive_line(0, L - H, 0, 0);
        normal_lines(2);
        chk("R9 broken run gives no event", vfalls - base, 0);

        // Sync loss and recovery.
        for (int i = 0; i < 5; i++) drive_line(0, 0, 0, 0);
        chk("R7 loss after quiet window", int'(lost), 1);
        normal_lines(15);
        chk("R8 still lost after 15 lines", int'(lost), 1);
        normal_lines(1);
        chk("R8 cleared after 16 lines", int'(lost), 0);

        // Reset during an active coast window.
        std = 2'b01;
        drive_line(0, H, L / 2, L / 2 - H);
        for (int i = 0; i < 2; i++) drive_line(0, L / 2 - H, L / 2, L / 2 - H);
        normal_lines(2);
        chk("R6 coast active before reset", int'(co_n), 0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 vsync_n after reset", int'(vs_n), 1);
        chk("R1 coast_n after reset", int'(co_n), 1);
        chk("R1 field_even after reset", int'(fe), 0);
        chk("R1 sync_lost after reset", int'(lost), 1);
        rst_n = 1'b1;
        normal_lines(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule